// File: doc/BRIEF.md
# Configuration Write ID Capture

This block listens to a multiplexed address/data bus and records the bus number and device number that the host assigns to one function. The host hands these out through Type 0 configuration writes. Every configuration write that reaches this function updates both numbers, whichever register it targets. The device number is taken from the address phase and the bus number from the attribute phase that comes right after it. Data phases and target signalling are not part of this block.

The captured numbers, the fixed function number and a bus-width indication from a strap pin form one 32-bit status word. A combinational read port returns that word when its offset input selects it and returns zero for any other offset.

Top module: `cfg_id_capture`

## Requirements
- R1: After reset the status word reads 0x0001_FFF8 with the strap high: bus number FFh in bits 15:8, device number 1Fh in bits 7:3, function number 0 in bits 2:0, bit 16 set.
- R2: A qualifying write loads bits 15:8 from AD[7:0] of the attribute phase. A write qualifies when the address-phase command on cbe_n is 1011b, idsel is high, AD[1:0] is 00b and AD[10:8] equals the function number (0). The new value reads back from the first falling clock edge after the rising edge that ends the attribute phase.
- R3: A qualifying write loads bits 7:3 from AD[15:11] of the address phase, in the same cycle as the bus number.
- R4: An address phase whose command is not 1011b (configuration read 1010b or memory write 0111b, for example) leaves both fields unchanged.
- R5: A write with idsel low during the address phase leaves both fields unchanged.
- R6: A write with AD[1:0] other than 00b (not Type 0) leaves both fields unchanged.
- R7: A write with AD[10:8] different from the function number leaves both fields unchanged.
- R8: Capture does not depend on the register offset in AD[7:2]. Offsets 00h, FCh and E4h all capture.
- R9: Bit 16 follows strap_w32_n: 1 for a 64-bit bus, 0 when the strap is pulled low. It updates combinationally.
- R10: rd_word is the status word when rd_offset is E4h and all zero for any other offset. Bits 31:17 always read zero.
- R11: Only the first clock with frame_n low after a clock with frame_n high is an address phase. Later clocks of the same transaction never start a capture, even when they carry values that would qualify.
- R12: Bits 2:0 always read as the fixed function number 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_n | input | 1 | Active-low transaction framing |
| idsel | input | 1 | Configuration select for this device |
| cbe_n | input | 4 | Command during the address phase |
| ad | input | 16 | Low address/data lines AD[15:0] |
| strap_w32_n | input | 1 | Active-low 32-bit width strap |
| rd_offset | input | 8 | Byte offset for the status read |
| rd_word | output | 32 | Status word read-back |

## Verification
A capture starts at the rising edge where the address phase is sampled. It becomes visible after the next rising edge, the one that ends the attribute phase, so it is due two edges after the address phase is driven. The read port and the width bit are combinational and due in the same cycle as rd_offset or the strap changes. The bench drives inputs and compares on falling edges. A behavioural model updates on every rising edge and is compared with rd_word on every falling edge, so each result is checked in the first half cycle in which it must hold.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam logic [3:0] CMD_CFG_WRITE = 4'b1011;
  localparam logic [1:0] CFG_TYPE0     = 2'b00;
  localparam int unsigned STATUS_W     = 32;
  localparam int unsigned AD_LO_W      = 16;

  typedef struct packed {
    logic [7:0] bus;
    logic [4:0] dev;
  } cic_id_t;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_GOT_ADDR = 2'd1,
    ST_IN_XACT  = 2'd2
  } cic_phase_e;
endpackage

// File: rtl/cic_rst_sync.sv
module cic_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cic_phase_track.sv
module cic_phase_track
  import cic_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  output logic addr_stb,
  output logic attr_stb
);
  cic_phase_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (!frame_n) state_d = ST_GOT_ADDR;
      ST_GOT_ADDR: state_d = frame_n ? ST_IDLE : ST_IN_XACT;
      ST_IN_XACT:  if (frame_n) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign addr_stb = (state_q == ST_IDLE) && !frame_n;
  assign attr_stb = (state_q == ST_GOT_ADDR);
endmodule

// File: rtl/cic_addr_qual.sv
module cic_addr_qual
  import cic_pkg::*;
#(
  parameter int unsigned FUNC_NUM = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_stb,
  input  logic [3:0] cbe_n,
  input  logic       idsel,
  input  logic [1:0] type_field,
  input  logic [2:0] fn_field,
  input  logic [4:0] dev_field,
  output logic       qual_ok,
  output logic [4:0] dev_hold
);
  localparam logic [2:0] FN_BITS = FUNC_NUM[2:0];

  logic       match;
  logic       qual_q, qual_d;
  logic [4:0] dev_q, dev_d;

  assign match = (cbe_n == CMD_CFG_WRITE) && idsel &&
                 (type_field == CFG_TYPE0) && (fn_field == FN_BITS);

  always_comb begin
    qual_d = qual_q;
    dev_d  = dev_q;
    if (addr_stb) begin
      qual_d = match;
      dev_d  = dev_field;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qual_q <= 1'b0;
      dev_q  <= '0;
    end else begin
      qual_q <= qual_d;
      dev_q  <= dev_d;
    end
  end

  assign qual_ok  = qual_q;
  assign dev_hold = dev_q;
endmodule

// File: rtl/cic_id_regs.sv
module cic_id_regs
  import cic_pkg::*;
#(
  parameter logic [7:0] BUS_RST = 8'hFF,
  parameter logic [4:0] DEV_RST = 5'h1F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       attr_stb,
  input  logic       qual_ok,
  input  logic [7:0] bus_field,
  input  logic [4:0] dev_hold,
  output cic_id_t    id_q
);
  cic_id_t id_d;
  logic    load;

  assign load = attr_stb && qual_ok;

  always_comb begin
    id_d = id_q;
    if (load) begin
      id_d.bus = bus_field;
      id_d.dev = dev_hold;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q.bus <= BUS_RST;
      id_q.dev <= DEV_RST;
    end else begin
      id_q <= id_d;
    end
  end
endmodule

// File: rtl/cic_status_read.sv
module cic_status_read
  import cic_pkg::*;
#(
  parameter int unsigned FUNC_NUM    = 0,
  parameter logic [7:0]  STATUS_OFFS = 8'hE4
) (
  input  cic_id_t              id_q,
  input  logic                 strap_w32_n,
  input  logic [7:0]           rd_offset,
  output logic [STATUS_W-1:0]  rd_word
);
  localparam logic [2:0] FN_BITS = FUNC_NUM[2:0];

  logic [STATUS_W-1:0] word;

  always_comb begin
    word        = '0;
    word[16]    = strap_w32_n;
    word[15:8]  = id_q.bus;
    word[7:3]   = id_q.dev;
    word[2:0]   = FN_BITS;
  end

  assign rd_word = (rd_offset == STATUS_OFFS) ? word : '0;
endmodule

// File: rtl/cfg_id_capture.sv
module cfg_id_capture
  import cic_pkg::*;
#(
  parameter int unsigned FUNC_NUM    = 0,
  parameter logic [7:0]  STATUS_OFFS = 8'hE4,
  parameter logic [7:0]  BUS_RST     = 8'hFF,
  parameter logic [4:0]  DEV_RST     = 5'h1F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_n,
  input  logic        idsel,
  input  logic [3:0]  cbe_n,
  input  logic [15:0] ad,
  input  logic        strap_w32_n,
  input  logic [7:0]  rd_offset,
  output logic [31:0] rd_word
);
  logic       rst_core_n;
  logic       addr_stb, attr_stb;
  logic       qual_ok;
  logic [4:0] dev_hold;
  cic_id_t    id_q;

  cic_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  cic_phase_track u_phase (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .frame_n  (frame_n),
    .addr_stb (addr_stb),
    .attr_stb (attr_stb)
  );

  cic_addr_qual #(.FUNC_NUM(FUNC_NUM)) u_qual (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .addr_stb   (addr_stb),
    .cbe_n      (cbe_n),
    .idsel      (idsel),
    .type_field (ad[1:0]),
    .fn_field   (ad[10:8]),
    .dev_field  (ad[15:11]),
    .qual_ok    (qual_ok),
    .dev_hold   (dev_hold)
  );

  cic_id_regs #(.BUS_RST(BUS_RST), .DEV_RST(DEV_RST)) u_ids (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .attr_stb  (attr_stb),
    .qual_ok   (qual_ok),
    .bus_field (ad[7:0]),
    .dev_hold  (dev_hold),
    .id_q      (id_q)
  );

  cic_status_read #(.FUNC_NUM(FUNC_NUM), .STATUS_OFFS(STATUS_OFFS)) u_read (
    .id_q        (id_q),
    .strap_w32_n (strap_w32_n),
    .rd_offset   (rd_offset),
    .rd_word     (rd_word)
  );
endmodule

// File: rtl/cfg_id_capture_chk.sv
module cfg_id_capture_chk #(
  parameter int unsigned FUNC_NUM    = 0,
  parameter logic [7:0]  STATUS_OFFS = 8'hE4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_n,
  input logic        idsel,
  input logic [3:0]  cbe_n,
  input logic [15:0] ad,
  input logic        strap_n,
  input logic [7:0]  rd_offset,
  input logic [31:0] rd_word,
  input logic [7:0]  bus_q,
  input logic [4:0]  dev_q
);
  logic       frame_prev_c;
  logic       hit_c;
  logic [4:0] dev_c;
  logic       start_ok;

  assign start_ok = !frame_n && frame_prev_c && (cbe_n == 4'b1011) && idsel &&
                    (ad[1:0] == 2'b00) && (ad[10:8] == FUNC_NUM[2:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_prev_c <= 1'b1;
      hit_c        <= 1'b0;
      dev_c        <= '0;
    end else begin
      frame_prev_c <= frame_n;
      hit_c        <= start_ok;
      dev_c        <= ad[15:11];
    end
  end

  // R4 R5 R6 R7 R11: no qualified address phase one cycle earlier, no change
  a_r4_hold_unless_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_c |=> ($stable(bus_q) && $stable(dev_q)));

  a_r2_bus_from_attr: assert property (@(posedge clk) disable iff (!rst_n)
    hit_c |=> (bus_q == $past(ad[7:0])));

  a_r3_dev_from_addr: assert property (@(posedge clk) disable iff (!rst_n)
    hit_c |=> (dev_q == $past(dev_c)));

  a_r9_width_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_offset == STATUS_OFFS) |-> (rd_word[16] == strap_n));

  a_r10_other_offset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_offset != STATUS_OFFS) |-> (rd_word == 32'h0));

  a_r12_func_and_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_offset == STATUS_OFFS) |->
      ((rd_word[2:0] == FUNC_NUM[2:0]) && (rd_word[31:17] == 15'h0)));

  a_r2_readback_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_offset == STATUS_OFFS) |-> ((rd_word[15:8] == bus_q) && (rd_word[7:3] == dev_q)));
endmodule

bind cfg_id_capture cfg_id_capture_chk #(
  .FUNC_NUM(FUNC_NUM), .STATUS_OFFS(STATUS_OFFS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .frame_n   (frame_n),
  .idsel     (idsel),
  .cbe_n     (cbe_n),
  .ad        (ad),
  .strap_n   (strap_w32_n),
  .rd_offset (rd_offset),
  .rd_word   (rd_word),
  .bus_q     (id_q.bus),
  .dev_q     (id_q.dev)
);

// File: tb/cfg_id_capture_bench.sv
module cfg_id_capture_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        frame_n;
  logic        idsel;
  logic [3:0]  cbe_n;
  logic [15:0] ad;
  logic        strap_w32_n;
  logic [7:0]  rd_offset;
  logic [31:0] rd_word;

  int    total = 0;
  int    bad   = 0;
  string tag   = "R1";

  // behavioural reference state
  int       m_rst_cnt = 0;
  bit [7:0] m_bus = 8'hFF;
  bit [4:0] m_dev = 5'h1F;
  bit       m_prev_high = 1;
  bit       m_pend = 0;
  bit       m_qual = 0;
  bit [4:0] m_dev_hold = 0;

  cfg_id_capture u_cfg_id_capture (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .idsel(idsel), .cbe_n(cbe_n),
    .ad(ad), .strap_w32_n(strap_w32_n), .rd_offset(rd_offset), .rd_word(rd_word)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rst_cnt = 0; m_bus = 8'hFF; m_dev = 5'h1F;
      m_prev_high = 1; m_pend = 0; m_qual = 0;
    end else if (m_rst_cnt < 2) begin
      m_rst_cnt++;
    end else begin
      if (m_pend && m_qual) begin
        m_bus = ad[7:0];
        m_dev = m_dev_hold;
      end
      m_pend = 0;
      if (!frame_n && m_prev_high) begin
        m_pend     = 1;
        m_qual     = (cbe_n == 4'b1011) && idsel && (ad[1:0] == 0) && (ad[10:8] == 0);
        m_dev_hold = ad[15:11];
      end
      m_prev_high = frame_n;
    end
  end

  function automatic logic [31:0] model_word();
    if (rd_offset != 8'hE4) return 32'h0;
    return {15'h0, strap_w32_n, m_bus, m_dev, 3'b000};
  endfunction

  task automatic check_word(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic f, logic s, logic [3:0] c, logic [15:0] a);
    @(negedge clk);
    check_word(tag, rd_word, model_word());
    frame_n = f; idsel = s; cbe_n = c; ad = a;
  endtask

  task automatic idle(int n);
    repeat (n) step(1'b1, 1'b0, 4'hF, 16'h0000);
  endtask

  task automatic xact(logic [3:0] cmd, logic sel, logic [15:0] addr, logic [15:0] attr,
                      int ndata, logic [3:0] dcbe, logic [15:0] dval);
    step(1'b0, sel, cmd, addr);
    step(1'b0, 1'b0, 4'hF, attr);
    for (int i = 0; i < ndata; i++) step(1'b0, 1'b1, dcbe, dval);
    idle(2);
  endtask

  task automatic expect_word(string req, logic [31:0] exp);
    @(negedge clk);
    check_word(req, rd_word, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; frame_n = 1'b1; idsel = 1'b0; cbe_n = 4'hF; ad = 16'h0;
    strap_w32_n = 1'b1; rd_offset = 8'hE4;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1";
    idle(5);
    expect_word("R1", 32'h0001_FFF8);

    tag = "R2";
    xact(4'b1011, 1'b1, 16'h5010, 16'h003C, 0, 4'hF, 16'h0);
    expect_word("R2", 32'h0001_3C50);
    check_word("R3", {27'h0, rd_word[7:3]}, 32'h0000_000A);

    tag = "R4";
    xact(4'b1010, 1'b1, 16'h8800, 16'h0077, 0, 4'hF, 16'h0);
    xact(4'b0111, 1'b1, 16'h8800, 16'h0077, 0, 4'hF, 16'h0);
    expect_word("R4", 32'h0001_3C50);

    tag = "R5";
    xact(4'b1011, 1'b0, 16'h8800, 16'h0077, 0, 4'hF, 16'h0);
    expect_word("R5", 32'h0001_3C50);

    tag = "R6";
    xact(4'b1011, 1'b1, 16'h8801, 16'h0077, 0, 4'hF, 16'h0);
    expect_word("R6", 32'h0001_3C50);

    tag = "R7";
    xact(4'b1011, 1'b1, 16'h8900, 16'h0077, 0, 4'hF, 16'h0);
    expect_word("R7", 32'h0001_3C50);

    tag = "R8";
    xact(4'b1011, 1'b1, 16'h10FC, 16'h0001, 0, 4'hF, 16'h0);
    expect_word("R8", 32'h0001_0110);
    xact(4'b1011, 1'b1, 16'hF000, 16'h00A5, 0, 4'hF, 16'h0);
    expect_word("R8", 32'h0001_A5F0);
    xact(4'b1011, 1'b1, 16'h18E4, 16'h0042, 0, 4'hF, 16'h0);
    expect_word("R8", 32'h0001_4218);

    tag = "R9";
    strap_w32_n = 1'b0;
    expect_word("R9", 32'h0000_4218);
    idle(1);
    strap_w32_n = 1'b1;
    expect_word("R9", 32'h0001_4218);

    tag = "R10";
    rd_offset = 8'hE0;
    expect_word("R10", 32'h0);
    rd_offset = 8'hE5;
    expect_word("R10", 32'h0);
    rd_offset = 8'hFF;
    idle(2);
    rd_offset = 8'hE4;
    expect_word("R10", 32'h0001_4218);

    tag = "R11";
    xact(4'b0110, 1'b1, 16'h0800, 16'h0099, 3, 4'b1011, 16'h2800);
    expect_word("R11", 32'h0001_4218);
    xact(4'b1011, 1'b1, 16'h3000, 16'h0055, 4, 4'b1011, 16'h48AA);
    expect_word("R11", 32'h0001_5530);

    tag = "R12";
    idle(1);
    check_word("R12", {29'h0, rd_word[2:0]}, 32'h0);

    idle(3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule